// File: doc/BRIEF.md
# MAC Pipeline Spacing Guard

This block sits beside the decode stage of a four-stage fetch/decode/execute/writeback pipeline that carries a multiply-accumulate coprocessor. That coprocessor shares its address pointers and result registers with the standard ALU. Each cycle, the decode stage gives the block a descriptor for the instruction it holds. The descriptor has a valid bit, an instruction class (MAC or standard), masks of the pointer and offset registers the instruction writes and the ones its MAC addressing uses, and masks of the coprocessor result registers it writes and reads. The block compares this descriptor with the history of the instruction accepted just before it and reports any pair that breaks the spacing rules.

There are two rules, and they do not mirror each other. First, a MAC instruction may not use a pointer or offset register in its addressing if the instruction directly before it wrote that register. Second, a coprocessor result register written by a MAC instruction stays unreadable by standard instructions until at least one non-MAC slot has passed. This is because the accumulator and the coprocessor flags only settle at the end of execute. The block has two modes. In flag mode it reports each offending instruction with a violation flag and a cause code. In stall mode it asks for one bubble: decode keeps the instruction for one more cycle, a NOP goes forward in its place, and the held instruction then passes cleanly.

Top module: `mac_spacing_guard`

## Requirements
- R1: A valid MAC instruction whose `slot_ptr_use` overlaps the `slot_ptr_wr` of the instruction accepted in the cycle directly before it is a pointer hazard, reported as cause 2'b01. Bit mapping: bits 0-1 are index pointers 0 and 1, bits 2-3 are step offsets X0 and X1, bits 4-5 are step offsets R0 and R1.
- R2: No pointer hazard arises if the MAC instruction uses only registers that the directly preceding instruction did not write. The same holds if one slot separates the write and the use, whether that slot holds a standard instruction or is an idle slot (`slot_valid` low).
- R3: A standard instruction that uses a pointer written by the instruction directly before it never causes a hazard.
- R4: A valid standard instruction whose `slot_creg_rd` overlaps any register written by a MAC instruction is a result-register hazard, reported as cause 2'b10, if no non-MAC slot came between them. Intervening MAC instructions do not count as separation. Bit mapping: 0 accumulator high, 1 accumulator low, 2 status, 3 repeat count, 4 control.
- R5: Any single standard instruction or idle slot clears the pending result-register writes. A standard read of a register that was not written, and a MAC read of a just-written register, are not hazards.
- R6: The cause code is 2'b00 when there is no hazard. It is never 2'b11, because the two hazards need different instruction classes. An idle slot drives no flag, no stall and cause 2'b00.
- R7: In flag mode (`stall_mode` low), a hazard raises `viol` in the same cycle, with `stall_req` low. The flagged instruction is still accepted, so its own writes are tracked for the next instruction.
- R8: In stall mode, a hazard raises `stall_req` with `viol` low and the cause code shown. The stall cycle counts as a NOP slot, so when the same instruction is presented again in the next cycle it passes with no flag and no stall.
- R9: Reset clears all tracking, so the first instruction after reset never flags or stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_mode | input | 1 | 1: request a bubble on hazard; 0: flag only |
| slot_valid | input | 1 | Decode slot holds an instruction |
| slot_is_mac | input | 1 | Instruction is a MAC-class instruction |
| slot_ptr_wr | input | 6 | Pointer/offset registers the instruction updates |
| slot_ptr_use | input | 6 | Pointer/offset registers used in MAC addressing |
| slot_creg_wr | input | 5 | Coprocessor result registers written |
| slot_creg_rd | input | 5 | Coprocessor result registers read |
| viol | output | 1 | Spacing violation (flag mode) |
| cause | output | 2 | Hazard cause code |
| stall_req | output | 1 | One-cycle bubble request (stall mode) |

## Verification
The assertions assume that the descriptor is stable across each clock edge and that, in stall mode, decode presents the same instruction again in the cycle after a stall. The pointer-hazard property also assumes that a slot with `slot_valid` low is a true gap, whatever masks it carries. The bench drives each descriptor at the falling edge and clears every mask on idle slots. After each stall it presents the held instruction again on the next cycle, so the stimulus stays inside these assumptions.

// File: rtl/msg_pkg.sv
package msg_pkg;

    localparam int unsigned N_IDX  = 2;
    localparam int unsigned N_QX   = 2;
    localparam int unsigned N_QR   = 2;
    localparam int unsigned N_CREG = 5;
    localparam int unsigned N_PTR  = N_IDX + N_QX + N_QR;

    typedef logic [N_PTR-1:0]  ptr_mask_t;
    typedef logic [N_CREG-1:0] creg_mask_t;

    typedef struct packed {
        logic       valid;
        logic       is_mac;
        ptr_mask_t  ptr_wr;
        ptr_mask_t  ptr_use;
        creg_mask_t creg_wr;
        creg_mask_t creg_rd;
    } slot_t;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_PTR  = 2'b01,
        CAUSE_CREG = 2'b10,
        CAUSE_BOTH = 2'b11
    } cause_e;

    function automatic cause_e make_cause(input logic ptr_hit, input logic creg_hit);
        return cause_e'({creg_hit, ptr_hit});
    endfunction

endpackage

// File: rtl/msg_ptr_track.sv
module msg_ptr_track
    import msg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  logic      cur_valid,
    input  logic      cur_mac,
    input  ptr_mask_t cur_wr,
    input  ptr_mask_t cur_use,
    output logic      hit
);
    ptr_mask_t wr_last;

    // one "written last slot" bit per pointer/offset register
    for (genvar i = 0; i < N_PTR; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) wr_last[i] <= 1'b0;
            else     wr_last[i] <= accept & cur_wr[i];
        end
    end

    always_comb hit = cur_valid & cur_mac & (|(cur_use & wr_last));

endmodule

// File: rtl/msg_creg_track.sv
module msg_creg_track
    import msg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  logic       cur_valid,
    input  logic       cur_mac,
    input  creg_mask_t cur_wr,
    input  creg_mask_t cur_rd,
    output logic       hit
);
    creg_mask_t pending;

    // MAC writes accumulate across back-to-back MAC slots; any non-MAC slot
    // (standard instruction, idle slot or inserted bubble) retires them
    always_ff @(posedge clk) begin
        if (rst)           pending <= '0;
        else if (!accept)  pending <= '0;
        else if (cur_mac)  pending <= pending | cur_wr;
        else               pending <= '0;
    end

    always_comb hit = cur_valid & ~cur_mac & (|(cur_rd & pending));

endmodule

// File: rtl/msg_verdict.sv
module msg_verdict
    import msg_pkg::*;
(
    input  logic   stall_mode,
    input  logic   valid,
    input  logic   ptr_hit,
    input  logic   creg_hit,
    output logic   accept,
    output logic   viol,
    output logic   stall_req,
    output cause_e cause
);
    logic hazard;

    always_comb begin
        hazard    = ptr_hit | creg_hit;
        stall_req = stall_mode & hazard;
        viol      = ~stall_mode & hazard;
        accept    = valid & ~stall_req;
        cause     = make_cause(ptr_hit, creg_hit);
    end

endmodule

// File: rtl/mac_spacing_guard.sv
module mac_spacing_guard
    import msg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stall_mode,
    input  logic              slot_valid,
    input  logic              slot_is_mac,
    input  logic [N_PTR-1:0]  slot_ptr_wr,
    input  logic [N_PTR-1:0]  slot_ptr_use,
    input  logic [N_CREG-1:0] slot_creg_wr,
    input  logic [N_CREG-1:0] slot_creg_rd,
    output logic              viol,
    output logic [1:0]        cause,
    output logic              stall_req
);
    slot_t  cur;
    logic   accept;
    logic   ptr_hit;
    logic   creg_hit;
    cause_e cause_w;

    always_comb begin
        cur.valid   = slot_valid;
        cur.is_mac  = slot_is_mac;
        cur.ptr_wr  = slot_ptr_wr;
        cur.ptr_use = slot_ptr_use;
        cur.creg_wr = slot_creg_wr;
        cur.creg_rd = slot_creg_rd;
    end

    msg_ptr_track u_ptr (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .cur_valid (cur.valid),
        .cur_mac   (cur.is_mac),
        .cur_wr    (cur.ptr_wr),
        .cur_use   (cur.ptr_use),
        .hit       (ptr_hit)
    );

    msg_creg_track u_creg (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .cur_valid (cur.valid),
        .cur_mac   (cur.is_mac),
        .cur_wr    (cur.creg_wr),
        .cur_rd    (cur.creg_rd),
        .hit       (creg_hit)
    );

    msg_verdict u_verdict (
        .stall_mode (stall_mode),
        .valid      (cur.valid),
        .ptr_hit    (ptr_hit),
        .creg_hit   (creg_hit),
        .accept     (accept),
        .viol       (viol),
        .stall_req  (stall_req),
        .cause      (cause_w)
    );

    assign cause = cause_w;

endmodule

// File: rtl/mac_spacing_guard_chk.sv
module mac_spacing_guard_chk
    import msg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              stall_mode,
    input logic              slot_valid,
    input logic              slot_is_mac,
    input logic [N_PTR-1:0]  slot_ptr_wr,
    input logic [N_PTR-1:0]  slot_ptr_use,
    input logic [N_CREG-1:0] slot_creg_rd,
    input logic              viol,
    input logic [1:0]        cause,
    input logic              stall_req
);
    assert_ptr_hazard_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(slot_valid && !stall_req) && slot_valid && slot_is_mac
         && (|(slot_ptr_use & $past(slot_ptr_wr)))) |-> cause[0]);

    assert_std_ptr_free_R3: assert property (@(posedge clk) disable iff (rst)
        (slot_valid && !slot_is_mac) |-> !cause[0]);

    assert_mac_read_free_R5: assert property (@(posedge clk) disable iff (rst)
        (slot_valid && slot_is_mac) |-> !cause[1]);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !slot_valid |-> (!viol && !stall_req && cause == 2'b00));

    assert_no_both_R6: assert property (@(posedge clk) disable iff (rst)
        cause != 2'b11);

    assert_flag_only_unstalled_R7: assert property (@(posedge clk) disable iff (rst)
        viol |-> (!stall_mode && cause != 2'b00));

    assert_stall_only_mode_R8: assert property (@(posedge clk) disable iff (rst)
        stall_req |-> stall_mode);

    assert_single_bubble_R8: assert property (@(posedge clk) disable iff (rst)
        stall_req |=> !stall_req);

    assert_clean_after_reset_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!viol && !stall_req));

    // slot_creg_rd is carried for completeness of the observed slot
    logic unused_ok;
    assign unused_ok = ^slot_creg_rd;

endmodule

bind mac_spacing_guard mac_spacing_guard_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .stall_mode   (stall_mode),
    .slot_valid   (slot_valid),
    .slot_is_mac  (slot_is_mac),
    .slot_ptr_wr  (slot_ptr_wr),
    .slot_ptr_use (slot_ptr_use),
    .slot_creg_rd (slot_creg_rd),
    .viol         (viol),
    .cause        (cause),
    .stall_req    (stall_req)
);

// File: tb/mac_spacing_guard_bench.sv
`timescale 1ns/1ps
module mac_spacing_guard_bench;
    import msg_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              stall_mode = 1'b0;
    logic              slot_valid = 1'b0;
    logic              slot_is_mac = 1'b0;
    logic [N_PTR-1:0]  slot_ptr_wr = '0;
    logic [N_PTR-1:0]  slot_ptr_use = '0;
    logic [N_CREG-1:0] slot_creg_wr = '0;
    logic [N_CREG-1:0] slot_creg_rd = '0;
    logic              viol;
    logic [1:0]        cause;
    logic              stall_req;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    mac_spacing_guard u_mac_spacing_guard (.*);

    // drive at the falling edge, check 1 ns later, well before the rising edge
    task automatic issue(input logic v, input logic mac,
                         input logic [N_PTR-1:0] pw, input logic [N_PTR-1:0] pu,
                         input logic [N_CREG-1:0] cw, input logic [N_CREG-1:0] cr,
                         input logic ev, input logic es, input logic [1:0] ec,
                         input string req);
        @(negedge clk);
        slot_valid = v; slot_is_mac = mac; slot_ptr_wr = pw; slot_ptr_use = pu;
        slot_creg_wr = cw; slot_creg_rd = cr;
        #1;
        checks++;
        if (viol !== ev || stall_req !== es || cause !== ec) begin
            errors++;
            $display("FAIL %s: viol/stall/cause = %b/%b/%b expected %b/%b/%b",
                     req, viol, stall_req, cause, ev, es, ec);
        end
    endtask

    task automatic idle(input string req);
        issue(0, 0, '0, '0, '0, '0, 0, 0, 2'b00, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; slot_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_clears();
        stall_mode = 0;
        issue(1, 1, 6'b000001, '0, 5'b00001, '0, 0, 0, 2'b00, "R9 setup");
        do_reset();
        issue(1, 0, '0, '0, '0, 5'b00001, 0, 0, 2'b00, "R9 creg read after reset");
        do_reset();
        issue(1, 1, 6'b000001, '0, '0, '0, 0, 0, 2'b00, "R9 setup ptr");
        do_reset();
        issue(1, 1, '0, 6'b000001, '0, '0, 0, 0, 2'b00, "R9 ptr use after reset");
    endtask

    task automatic t_ptr_rules();
        stall_mode = 0;
        idle("R6 idle quiet");
        issue(1, 0, 6'b000001, '0, '0, '0, 0, 0, 2'b00, "R1 write idx0");
        issue(1, 1, '0, 6'b000001, '0, '0, 1, 0, 2'b01, "R1 mac uses idx0");
        issue(1, 0, 6'b000100, '0, '0, '0, 0, 0, 2'b00, "R1 write qx0");
        issue(1, 1, '0, 6'b000110, '0, '0, 1, 0, 2'b01, "R1 mac uses qx0");
        issue(1, 0, 6'b010000, '0, '0, '0, 0, 0, 2'b00, "R2 write qr0");
        issue(1, 1, '0, 6'b100010, '0, '0, 0, 0, 2'b00, "R2 other regs");
        issue(1, 0, 6'b001000, '0, '0, '0, 0, 0, 2'b00, "R2 write qx1");
        issue(1, 0, '0, '0, '0, '0, 0, 0, 2'b00, "R2 std gap");
        issue(1, 1, '0, 6'b001000, '0, '0, 0, 0, 2'b00, "R2 after std gap");
        issue(1, 0, 6'b100000, '0, '0, '0, 0, 0, 2'b00, "R2 write qr1");
        idle("R2 idle gap");
        issue(1, 1, '0, 6'b100000, '0, '0, 0, 0, 2'b00, "R2 after idle gap");
        issue(1, 0, 6'b000010, '0, '0, '0, 0, 0, 2'b00, "R3 write idx1");
        issue(1, 0, '0, 6'b000010, '0, '0, 0, 0, 2'b00, "R3 std uses idx1");
    endtask

    task automatic t_creg_rules();
        stall_mode = 0;
        issue(1, 1, '0, '0, 5'b00001, '0, 0, 0, 2'b00, "R4 mac writes acc hi");
        issue(1, 0, '0, '0, '0, 5'b00001, 1, 0, 2'b10, "R4 std reads acc hi");
        issue(1, 1, '0, '0, 5'b00100, '0, 0, 0, 2'b00, "R4 mac writes status");
        issue(1, 1, '0, '0, '0, '0, 0, 0, 2'b00, "R4 mac in between");
        issue(1, 0, '0, '0, '0, 5'b00100, 1, 0, 2'b10, "R4 std reads status via mac");
        issue(1, 1, '0, '0, 5'b00010, '0, 0, 0, 2'b00, "R5 mac writes acc lo");
        issue(1, 0, '0, '0, '0, '0, 0, 0, 2'b00, "R5 std gap");
        issue(1, 0, '0, '0, '0, 5'b00010, 0, 0, 2'b00, "R5 read after gap");
        issue(1, 1, '0, '0, 5'b01000, '0, 0, 0, 2'b00, "R5 mac writes repeat");
        issue(1, 0, '0, '0, '0, 5'b10000, 0, 0, 2'b00, "R5 other register read");
        issue(1, 1, '0, '0, 5'b00001, '0, 0, 0, 2'b00, "R5 mac writes acc hi");
        issue(1, 1, '0, '0, '0, 5'b00001, 0, 0, 2'b00, "R5 mac reads acc hi");
        idle("R5 idle clears");
        issue(1, 0, '0, '0, '0, 5'b00001, 0, 0, 2'b00, "R5 read after idle");
    endtask

    task automatic t_flag_chain();
        stall_mode = 0;
        issue(1, 0, 6'b000010, '0, '0, '0, 0, 0, 2'b00, "R7 write idx1");
        issue(1, 1, 6'b000100, 6'b000010, '0, '0, 1, 0, 2'b01, "R7 flagged and writes qx0");
        issue(1, 1, '0, 6'b000100, '0, '0, 1, 0, 2'b01, "R7 flagged writes tracked");
    endtask

    task automatic t_stall_mode();
        stall_mode = 1;
        issue(1, 0, 6'b000001, '0, '0, '0, 0, 0, 2'b00, "R8 write idx0");
        issue(1, 1, '0, 6'b000001, '0, '0, 0, 1, 2'b01, "R8 stall on ptr");
        issue(1, 1, '0, 6'b000001, '0, '0, 0, 0, 2'b00, "R8 held passes");
        issue(1, 1, '0, '0, 5'b10000, '0, 0, 0, 2'b00, "R8 mac writes control");
        issue(1, 0, '0, '0, '0, 5'b10000, 0, 1, 2'b10, "R8 stall on creg");
        issue(1, 0, '0, '0, '0, 5'b10000, 0, 0, 2'b00, "R8 held read passes");
        stall_mode = 0;
    endtask

    initial begin
        do_reset();
        t_reset_clears();
        t_ptr_rules();
        t_creg_rules();
        t_flag_chain();
        t_stall_mode();
        idle("R6 final idle");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule